// File: doc/BRIEF.md
# Double-Banked Sample Buffer Controller

This block sits between a host that streams sample words in and a playback engine that pulls them out in fixed bursts. Storage is split into several banks. Each 64-bit word holds one channel's value for all four DACs at once. The host picks a bank and pushes words into it through a valid/ready stream. Words land at consecutive addresses starting at address 2. Playback works through one bank at a time. Each start pulse reads the next 32 words and presents them on a second valid/ready stream. Each word carries its DAC channel, computed as (address - 2) mod 32.

Once playback has started, the bank being played is protected. A host word aimed at it is consumed but dropped, and a sticky error flag is raised. When the last burst of a bank has been delivered, playback moves on to the next bank in cyclic order. So the host can refill the bank that is not in use while output continues without limit. The bank switch only happens on a burst boundary.

Back-pressure rules: the input side lowers `s_ready` only while a new fill bank is being taken over, or when the fill bank is full. A word transfers on any rising edge with `s_valid` and `s_ready` both high. On the output side, the block holds `m_valid`, `m_data` and `m_chan` steady until `m_ready` is seen high. It never withdraws a word it has offered.

Top module: `sbuf_bank_ctrl`

## Requirements
- R1: A host word transfers on a rising edge with `s_valid` and `s_ready` high. Words are stored in arrival order at addresses 2, 3, 4, ... of the fill bank.
- R2: When `host_bank` differs from the current fill bank, `s_ready` is low for one cycle. Filling then restarts at address 2 of the newly selected bank.
- R3: After a bank has received all of its words (4 bursts of 32 by default), `s_ready` stays low until `host_bank` selects another bank.
- R4: After the first `start`, a word aimed at the bank shown on `active_bank` is accepted (`s_ready` high) but not stored, and `wr_err` goes high. `wr_err` stays high until reset. Before the first `start`, no bank is protected.
- R5: A `start` pulse while no burst is running begins a burst of exactly 32 words read in ascending address order. A `start` during a burst is ignored and does not launch another burst.
- R6: Each output word has `m_chan` = (address - 2) mod 32, so every burst presents channels 0 to 31 in order.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_chan` hold. No word is lost or repeated under any `m_ready` pattern.
- R8: `burst_done` is high for exactly one cycle: the cycle after the edge that transfers the 32nd word.
- R9: After the last burst of a bank, `active_bank` advances to the next bank (the last bank wraps to 0) at the same edge that raises `burst_done`. The following burst starts at address 2 of that bank. The active bank never changes mid-burst.
- R10: After reset, `active_bank` = 0, `wr_err` = 0, `m_valid` = 0, `burst_done` = 0, and with `host_bank` = 0 `s_ready` = 1.
- R11: The host may fill a non-active bank while playback is running. That bank's new content is what plays once it becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Host word valid |
| s_ready | output | 1 | Block can take a host word |
| s_data | input | 64 | Host word, four DAC values |
| host_bank | input | 1 | Bank the host wants to fill |
| start | input | 1 | Pulse: begin the next 32-word burst |
| m_valid | output | 1 | Playback word valid |
| m_ready | input | 1 | Playback consumer takes the word |
| m_data | output | 64 | Playback word |
| m_chan | output | 5 | DAC channel of the playback word |
| burst_done | output | 1 | One-cycle pulse after the last word of a burst |
| active_bank | output | 1 | Bank currently used by playback |
| wr_err | output | 1 | Sticky: a host word targeted the active bank |

## Verification
The bench goes after the bank hand-over. It checks that `active_bank` flips exactly with the `burst_done` of the fourth burst, and that the next burst reads address 2 of the other bank. A design that switched early, or that resumed at the old address, would deliver the wrong generation of data. A word refused while its bank is active is placed where a later burst reads it back, so a design that stored it, or that advanced the fill pointer, shows a data mismatch. Playback runs under pseudo-random `m_ready` with a start pulse injected mid-burst. Dropped, repeated or reordered words would show up as channel or data mismatches, and an extra burst would show up as `m_valid` rising after the burst ends. The refill of the idle bank runs alongside playback, to catch writes that disturb the bank being read.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  typedef enum logic [1:0] {
    PL_PRE   = 2'd0,
    PL_WAIT  = 2'd1,
    PL_BURST = 2'd2
  } play_st_e;

  // cyclic successor of a bank index
  function automatic int unsigned bank_after(int unsigned b, int unsigned n);
    return (b + 1 >= n) ? 0 : b + 1;
  endfunction

endpackage

// File: rtl/sbuf_mem.sv
module sbuf_mem #(
  parameter int DATA_W     = 64,
  parameter int NUM_BANKS  = 2,
  parameter int BANK_DEPTH = 130,
  parameter int ADDR_W     = 8,
  parameter int BANK_W     = 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;
  logic [BANK_W-1:0]                sel_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] store [BANK_DEPTH];
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == BANK_W'(b)) store[wr_addr] <= wr_data;
      if (rd_en && rd_bank == BANK_W'(b)) q <= store[rd_addr];
    end
    assign bank_rd[b] = q;
  end

  always_ff @(posedge clk) begin
    if (rd_en) sel_q <= rd_bank;
  end

  assign rd_data = bank_rd[sel_q];

endmodule

// File: rtl/sbuf_fill_ctrl.sv
module sbuf_fill_ctrl #(
  parameter int DATA_W     = 64,
  parameter int NUM_BANKS  = 2,
  parameter int BANK_DEPTH = 130,
  parameter int ADDR_BASE  = 2,
  parameter int ADDR_W     = 8,
  parameter int BANK_W     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [BANK_W-1:0] host_bank,
  input  logic              armed,
  input  logic [BANK_W-1:0] active_bank,
  output logic              wr_en,
  output logic [BANK_W-1:0] wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_err
);

  logic [BANK_W-1:0] fill_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              err_q;
  logic              switching, full, blocked, accept;

  assign switching = (host_bank != fill_q);
  assign full      = (ptr_q == ADDR_W'(BANK_DEPTH));
  assign blocked   = (armed && fill_q == active_bank) ||
                     (32'(fill_q) >= NUM_BANKS);
  assign s_ready   = !switching && !full;
  assign accept    = s_valid && s_ready;

  assign wr_en   = accept && !blocked;
  assign wr_bank = fill_q;
  assign wr_addr = ptr_q;
  assign wr_data = s_data;
  assign wr_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      ptr_q  <= ADDR_W'(ADDR_BASE);
      err_q  <= 1'b0;
    end else begin
      if (switching) begin
        fill_q <= host_bank;
        ptr_q  <= ADDR_W'(ADDR_BASE);
      end else if (wr_en) begin
        ptr_q <= ptr_q + ADDR_W'(1);
      end
      if (accept && blocked) err_q <= 1'b1;
    end
  end

  // R4: once raised, the error flag never drops
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  // R3: pointer never runs past the end of a bank
  p_ptr_in_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == ADDR_W'(BANK_DEPTH)) |=> (ptr_q == ADDR_W'(BANK_DEPTH)) || (ptr_q == ADDR_W'(ADDR_BASE)));

endmodule

// File: rtl/sbuf_play_ctrl.sv
module sbuf_play_ctrl
  import sbuf_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BURST_LEN  = 32,
  parameter int BANK_DEPTH = 130,
  parameter int ADDR_BASE  = 2,
  parameter int ADDR_W     = 8,
  parameter int BANK_W     = 1,
  parameter int CHAN_W     = 5,
  parameter int CNT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [CHAN_W-1:0] m_chan,
  output logic              burst_done,
  output logic [BANK_W-1:0] active_bank,
  output logic              armed,
  output logic              rd_en,
  output logic [BANK_W-1:0] rd_bank,
  output logic [ADDR_W-1:0] rd_addr
);

  play_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic [CNT_W-1:0]  issue_q, take_q;
  logic              vld_q, done_q, armed_q;
  logic [CHAN_W-1:0] chan_q;
  logic              xfer;

  assign xfer  = vld_q && m_ready;
  assign rd_en = (st_q == PL_BURST) && (issue_q != '0) && (!vld_q || m_ready);

  assign m_valid     = vld_q;
  assign m_chan      = chan_q;
  assign burst_done  = done_q;
  assign active_bank = bank_q;
  assign armed       = armed_q;
  assign rd_bank     = bank_q;
  assign rd_addr     = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= PL_PRE;
      addr_q  <= ADDR_W'(ADDR_BASE);
      bank_q  <= '0;
      issue_q <= '0;
      take_q  <= '0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      done_q <= 1'b0;
      vld_q  <= rd_en || (vld_q && !m_ready);
      if (rd_en) begin
        addr_q  <= addr_q + ADDR_W'(1);
        issue_q <= issue_q - CNT_W'(1);
        chan_q  <= CHAN_W'(addr_q - ADDR_W'(ADDR_BASE));
      end
      case (st_q)
        PL_PRE, PL_WAIT: begin
          if (start) begin
            st_q    <= PL_BURST;
            issue_q <= CNT_W'(BURST_LEN);
            take_q  <= CNT_W'(BURST_LEN);
            armed_q <= 1'b1;
          end
        end
        PL_BURST: begin
          if (xfer) begin
            take_q <= take_q - CNT_W'(1);
            if (take_q == CNT_W'(1)) begin
              st_q   <= PL_WAIT;
              done_q <= 1'b1;
              if (addr_q == ADDR_W'(BANK_DEPTH)) begin
                addr_q <= ADDR_W'(ADDR_BASE);
                bank_q <= BANK_W'(bank_after(32'(bank_q), NUM_BANKS));
              end
            end
          end
        end
        default: st_q <= PL_WAIT;
      endcase
    end
  end

  // checker state: channel expected on the next delivered word
  logic [CHAN_W-1:0] exp_chan_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    exp_chan_q <= '0;
    else if (xfer) exp_chan_q <= m_chan + CHAN_W'(1);
  end

  // R6: delivered channels run 0..BURST_LEN-1 without gaps
  p_chan_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (m_chan == exp_chan_q));

  // R8: completion strobe lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  // R9: bank only changes at a burst end with nothing in flight
  p_bank_switch_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_bank != $past(active_bank)) |-> (burst_done && !m_valid));

  // R5: a start seen mid-burst does not reload the word count
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PL_BURST && start) |=> (take_q == $past(take_q)) || (take_q == $past(take_q) - CNT_W'(1)));

endmodule

// File: rtl/sbuf_bank_ctrl.sv
module sbuf_bank_ctrl #(
  parameter int DATA_W          = 64,
  parameter int NUM_BANKS       = 2,
  parameter int BURST_LEN       = 32,
  parameter int BURSTS_PER_BANK = 4,
  parameter int ADDR_BASE       = 2,
  localparam int BANK_DEPTH = ADDR_BASE + BURST_LEN * BURSTS_PER_BANK,
  localparam int ADDR_W     = $clog2(BANK_DEPTH + 1),
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CHAN_W     = $clog2(BURST_LEN),
  localparam int CNT_W      = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [BANK_W-1:0] host_bank,
  input  logic              start,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [CHAN_W-1:0] m_chan,
  output logic              burst_done,
  output logic [BANK_W-1:0] active_bank,
  output logic              wr_err
);

  logic              armed;
  logic              wr_en, rd_en;
  logic [BANK_W-1:0] wr_bank, rd_bank;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data;

  sbuf_fill_ctrl #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH),
    .ADDR_BASE(ADDR_BASE), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) i_fill (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .host_bank(host_bank), .armed(armed),
    .active_bank(active_bank), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err)
  );

  sbuf_play_ctrl #(
    .NUM_BANKS(NUM_BANKS), .BURST_LEN(BURST_LEN), .BANK_DEPTH(BANK_DEPTH),
    .ADDR_BASE(ADDR_BASE), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
    .CHAN_W(CHAN_W), .CNT_W(CNT_W)
  ) i_play (
    .clk(clk), .rst_n(rst_n), .start(start), .m_ready(m_ready),
    .m_valid(m_valid), .m_chan(m_chan), .burst_done(burst_done),
    .active_bank(active_bank), .armed(armed), .rd_en(rd_en),
    .rd_bank(rd_bank), .rd_addr(rd_addr)
  );

  sbuf_mem #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) i_mem (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .rd_data(m_data)
  );

  // R4: storage never written in the bank being played
  p_no_write_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && armed) |-> (wr_bank != active_bank));

  // R7: an offered word holds until taken
  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan)));

endmodule

// File: tb/test_sbuf_bank_ctrl.sv
`timescale 1ns/1ps
module test_sbuf_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [63:0] s_data = '0;
  logic [0:0]  host_bank = 1'b0;
  logic        start = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [63:0] m_data;
  logic [4:0]  m_chan;
  logic        burst_done;
  logic [0:0]  active_bank;
  logic        wr_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] lfsr = 8'h5B;

  always #10 clk = ~clk;

  sbuf_bank_ctrl i_sbuf_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .host_bank(host_bank), .start(start),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan),
    .burst_done(burst_done), .active_bank(active_bank), .wr_err(wr_err)
  );

  function automatic logic [63:0] pat(int bank, int idx, int gen);
    return {8'(8'hC3 ^ gen), 8'(bank), 16'(idx), 32'(idx * 32'h0101_0107 + gen)};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // push one host word; returns 1 if it transferred
  task automatic push(logic [63:0] d, output bit took);
    int w;
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    #1;
    w = 0;
    while (!s_ready && w < 50) begin
      @(negedge clk);
      #1;
      w++;
    end
    took = s_ready;
    @(posedge clk);
    #1;
    s_valid = 1'b0;
  endtask

  task automatic fill_bank(int bank, int gen);
    bit took;
    int lost;
    lost = 0;
    for (int i = 0; i < 128; i++) begin
      push(pat(bank, i, gen), took);
      if (!took) lost++;
    end
    chk(lost == 0, "R1", 64'(lost), 64'd0);
  endtask

  // one burst; expected words come from bank/idx0/gen
  task automatic run_burst(int bank, int idx0, int gen, bit bp, bit poke, int bank_after);
    int got, guard;
    bit rdy, stall;
    logic [63:0] hold_d;
    logic [4:0]  hold_c;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; guard = 0; stall = 1'b0;
    while (got < 32 && guard < 2000) begin
      if (stall) begin
        chk(m_valid && m_data == hold_d && m_chan == hold_c, "R7", m_data, hold_d);
      end
      start = (poke && got == 10) ? 1'b1 : 1'b0;
      rdy = bp ? lfsr[0] : 1'b1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      m_ready = rdy;
      stall = m_valid && !rdy;
      hold_d = m_data;
      hold_c = m_chan;
      if (m_valid && rdy) begin
        chk(m_data == pat(bank, idx0 + got, gen), "R5/R11 data", m_data, pat(bank, idx0 + got, gen));
        chk(m_chan == 5'(got), "R6", 64'(m_chan), 64'(got));
        got++;
      end
      @(negedge clk);
      guard++;
    end
    // this negedge follows the edge that took the 32nd word
    m_ready = 1'b0;
    start   = 1'b0;
    chk(got == 32, "R5 count", 64'(got), 64'd32);
    chk(burst_done == 1'b1, "R8 rise", 64'(burst_done), 64'd1);
    chk(active_bank == 1'(bank_after), "R9", 64'(active_bank), 64'(bank_after));
    @(negedge clk);
    chk(burst_done == 1'b0, "R8 width", 64'(burst_done), 64'd0);
    if (poke) begin
      repeat (5) begin
        @(negedge clk);
        chk(m_valid == 1'b0, "R5 ignored start", 64'(m_valid), 64'd0);
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(active_bank == 1'b0, "R10 bank", 64'(active_bank), 64'd0);
    chk(wr_err == 1'b0, "R10 err", 64'(wr_err), 64'd0);
    chk(m_valid == 1'b0, "R10 valid", 64'(m_valid), 64'd0);
    chk(burst_done == 1'b0, "R10 done", 64'(burst_done), 64'd0);
    chk(s_ready == 1'b1, "R10 ready", 64'(s_ready), 64'd1);
  endtask

  task automatic t_fill_initial();
    fill_bank(0, 1);
    @(negedge clk);
    #1;
    chk(s_ready == 1'b0, "R3 full", 64'(s_ready), 64'd0);
    host_bank = 1'b1;
    #1;
    chk(s_ready == 1'b0, "R2 takeover", 64'(s_ready), 64'd0);
    @(negedge clk);
    #1;
    chk(s_ready == 1'b1, "R2 ready again", 64'(s_ready), 64'd1);
    fill_bank(1, 2);
  endtask

  task automatic t_first_bank();
    run_burst(0, 0, 1, 1'b0, 1'b1, 0);
    run_burst(0, 32, 1, 1'b1, 1'b0, 0);
    run_burst(0, 64, 1, 1'b1, 1'b0, 0);
    run_burst(0, 96, 1, 1'b1, 1'b0, 1);
  endtask

  task automatic t_refuse();
    bit took;
    @(negedge clk);
    host_bank = 1'b0;
    @(negedge clk);
    host_bank = 1'b1;
    @(negedge clk);
    #1;
    chk(wr_err == 1'b0, "R4 err before", 64'(wr_err), 64'd0);
    push(64'hDEAD_BEEF_0BAD_F00D, took);
    chk(took == 1'b1, "R4 accepted", 64'(took), 64'd1);
    @(negedge clk);
    chk(wr_err == 1'b1, "R4 err set", 64'(wr_err), 64'd1);
  endtask

  task automatic t_second_bank_with_refill();
    run_burst(1, 0, 2, 1'b1, 1'b0, 1);
    fork
      begin
        @(negedge clk);
        host_bank = 1'b0;
        fill_bank(0, 3);
      end
      begin
        run_burst(1, 32, 2, 1'b1, 1'b0, 1);
        run_burst(1, 64, 2, 1'b0, 1'b0, 1);
        run_burst(1, 96, 2, 1'b1, 1'b0, 0);
      end
    join
    chk(wr_err == 1'b1, "R4 sticky", 64'(wr_err), 64'd1);
    run_burst(0, 0, 3, 1'b1, 1'b0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_fill_initial();
    t_first_bank();
    t_refuse();
    t_second_bank_with_refill();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule